// File: doc/BRIEF.md
# Bit-Serial Load/Store Sequencer

This block runs load and store instructions for a processor core whose datapath handles one bit per clock. Each memory instruction takes two counted serial passes of 32 cycles each. In the first pass the block receives the base register, the immediate and (for stores) the store operand, one bit per cycle with bit 0 first. While these bits arrive it adds base and offset into an address buffer, records the low address bits as they appear, and shifts the store operand into a data register.

When the first pass ends, the block checks the access for alignment. An aligned access opens one data-bus transaction: a cycle strobe stays high with address, write data, byte-lane mask and write enable until the target acknowledges. The read word is captured on the acknowledge. The second pass then starts. For a load, the selected and extended value goes out serially to the destination register, bit 0 first. A store only finishes its count in the second pass, so the core can advance its program counter. A misaligned access skips the bus. Instead the block gives a one-cycle trap pulse with a cause code and the faulting address, which the core uses to save its PC and jump to its handler.

Top module: `lsu_serial_seq`

## Requirements
- R1: After reset, `bus_cyc`, `bus_we`, `trap`, `rd_we` and `op_done` are all 0, and the block waits in its idle state for `op_start`.
- R2: The address is the 32-bit sum of the serial `rs1_bit` and `imm_bit` streams, taken bit 0 first and wrapping on overflow. `bus_adr` presents it with bits [1:0] forced to 0.
- R3: For an aligned access, `bus_cyc` rises in the first cycle after the 32nd operand bit is taken. It stays high until a cycle with `bus_ack` high, and it is low in the following cycle.
- R4: During a store access `bus_we` is 1. `bus_sel` (bit i enables bits [8i+7:8i]) is 4'b1111 for a word. For a halfword it is 4'b0011 at offset 0 and 4'b1100 at offset 2. For a byte it has only bit `addr[1:0]` set. `bus_wdat` repeats the low byte (byte access) or the low halfword (halfword access) of the store operand across all lanes, and is the whole operand for a word.
- R5: For a load, the word captured on `bus_ack` is shifted right by 8 times `addr[1:0]`. A byte access keeps bits [7:0] and a halfword access keeps bits [15:0]. The upper bits are filled with the top kept bit when `op_unsigned` is 0, and with zeros when it is 1. This value appears on `rd_bit`, bit 0 first, over the 32 cycles of the second pass with `rd_we` high.
- R6: A misaligned access never raises `bus_cyc`. In the cycle after the 32nd operand bit, `trap` is high for exactly one cycle. In that cycle `trap_cause` is 4 for a load or 6 for a store, and `trap_val` is the full unmasked address.
- R7: `op_size` encodes 0 = byte, 1 = halfword, 2 or 3 = word. A word access is misaligned when either address bit 0 or bit 1 is set. A halfword access is misaligned when address bit 0 is set. A byte access is never misaligned.
- R8: For a store, `rd_we` stays 0 through the whole second pass. For both loads and stores, `op_done` is high for exactly one cycle, in the final cycle of the second pass.
- R9: `op_start` and the operation fields are ignored outside the idle state. Changing them during a running operation does not affect its address, mask, write data or load result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Begin an operation (sampled only when idle) |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| op_unsigned | input | 1 | 1 = zero-extend load data, 0 = sign-extend |
| rs1_bit | input | 1 | Serial base register bit, bit 0 first |
| imm_bit | input | 1 | Serial immediate bit, bit 0 first |
| rs2_bit | input | 1 | Serial store operand bit, bit 0 first |
| bus_ack | input | 1 | Data bus acknowledge |
| bus_rdat | input | 32 | Data bus read word, valid with `bus_ack` |
| bus_cyc | output | 1 | Data bus cycle strobe |
| bus_we | output | 1 | Write enable, valid with `bus_cyc` |
| bus_adr | output | 32 | Word address, bits [1:0] zero |
| bus_sel | output | 4 | Byte lane enables |
| bus_wdat | output | 32 | Lane-replicated write data |
| init | output | 1 | High during the first serial pass |
| rd_bit | output | 1 | Serial load result bit |
| rd_we | output | 1 | Destination write strobe for `rd_bit` |
| op_done | output | 1 | Last cycle of the second pass |
| trap | output | 1 | One-cycle misalignment exception pulse |
| trap_cause | output | 4 | Exception cause code, valid with `trap` |
| trap_val | output | 32 | Faulting address, valid with `trap` |

## Verification
The embedded properties assume that the bus target raises `bus_ack` only while `bus_cyc` is high and holds it for a single cycle. The bench's bus model follows this: it waits a chosen number of cycles after the strobe rises and then pulses the acknowledge once. The properties also assume that operand bits are present in every cycle that `init` is high. The bench drives exactly 32 bits, starting in the cycle right after `op_start`. It raises `op_start` during a bus wait only to show that the request is ignored there.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int unsigned LSU_XLEN = 32;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam logic [3:0] CAUSE_LOAD_MISALIGN  = 4'd4;
    localparam logic [3:0] CAUSE_STORE_MISALIGN = 4'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_BUS,
        ST_TRAP,
        ST_FINAL
    } seq_state_t;

    function automatic logic is_misaligned(input logic [1:0] size, input logic [1:0] lo);
        case (size)
            SZ_BYTE: is_misaligned = 1'b0;
            SZ_HALF: is_misaligned = lo[0];
            default: is_misaligned = |lo;
        endcase
    endfunction

endpackage

// File: rtl/lsu_addr_acc.sv
module lsu_addr_acc #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned CNT_W = $clog2(XLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             a_bit,
    input  logic             b_bit,
    output logic [XLEN-1:0]  addr,
    output logic [1:0]       low
);

    typedef struct packed {
        logic [XLEN-1:0] acc;
        logic            carry;
        logic [1:0]      low;
    } acc_t;

    acc_t a_d, a_q;
    logic sum_bit;

    assign sum_bit = a_bit ^ b_bit ^ a_q.carry;

    always_comb begin
        a_d = a_q;
        if (clr) begin
            a_d.acc   = '0;
            a_d.carry = 1'b0;
            a_d.low   = 2'b00;
        end else if (en) begin
            a_d.acc   = {sum_bit, a_q.acc[XLEN-1:1]};
            a_d.carry = (a_bit & b_bit) | (a_q.carry & (a_bit ^ b_bit));
            if (bit_idx == CNT_W'(0)) a_d.low[0] = sum_bit;
            if (bit_idx == CNT_W'(1)) a_d.low[1] = sum_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign addr = a_q.acc;
    assign low  = a_q.low;

endmodule

// File: rtl/lsu_lane.sv
module lsu_lane #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned NB = XLEN / 8
) (
    input  logic [1:0]      size,
    input  logic            uns,
    input  logic [1:0]      off,
    input  logic [XLEN-1:0] sdata,
    input  logic [XLEN-1:0] rdata,
    output logic [NB-1:0]   sel,
    output logic [XLEN-1:0] wdat,
    output logic [XLEN-1:0] ldat
);

    logic is_byte, is_half;
    logic [XLEN-1:0] shifted;

    assign is_byte = (size == 2'd0);
    assign is_half = (size == 2'd1);

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign sel[i] = is_byte ? (off == 2'(i))
                      : is_half ? (off[1] == 1'((i / 2) % 2))
                      : 1'b1;
        assign wdat[8*i +: 8] = is_byte ? sdata[7:0]
                              : is_half ? sdata[8*(i % 2) +: 8]
                              : sdata[8*i +: 8];
    end

    assign shifted = rdata >> {off, 3'b000};

    always_comb begin
        if (is_byte)
            ldat = {{(XLEN-8){~uns & shifted[7]}}, shifted[7:0]};
        else if (is_half)
            ldat = {{(XLEN-16){~uns & shifted[15]}}, shifted[15:0]};
        else
            ldat = shifted;
    end

endmodule

// File: rtl/lsu_serial_seq.sv
module lsu_serial_seq
    import lsu_pkg::*;
#(
    parameter int unsigned XLEN = LSU_XLEN,
    localparam int unsigned CNT_W = $clog2(XLEN),
    localparam int unsigned NB = XLEN / 8,
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(XLEN - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_start,
    input  logic            op_store,
    input  logic [1:0]      op_size,
    input  logic            op_unsigned,
    input  logic            rs1_bit,
    input  logic            imm_bit,
    input  logic            rs2_bit,
    input  logic            bus_ack,
    input  logic [XLEN-1:0] bus_rdat,
    output logic            bus_cyc,
    output logic            bus_we,
    output logic [XLEN-1:0] bus_adr,
    output logic [NB-1:0]   bus_sel,
    output logic [XLEN-1:0] bus_wdat,
    output logic            init,
    output logic            rd_bit,
    output logic            rd_we,
    output logic            op_done,
    output logic            trap,
    output logic [3:0]      trap_cause,
    output logic [XLEN-1:0] trap_val
);

    typedef struct packed {
        seq_state_t       state;
        logic [CNT_W-1:0] cnt;
        logic             store;
        logic [1:0]       size;
        logic             uns;
        logic [XLEN-1:0]  data;
        logic [XLEN-1:0]  ldat;
    } seq_t;

    seq_t s_d, s_q;

    logic [XLEN-1:0] addr;
    logic [1:0]      low;
    logic [XLEN-1:0] lane_ldat;
    logic            acc_clr, acc_en;

    assign acc_clr = (s_q.state == ST_IDLE) && op_start;
    assign acc_en  = (s_q.state == ST_INIT);

    lsu_addr_acc #(.XLEN(XLEN)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .en      (acc_en),
        .bit_idx (s_q.cnt),
        .a_bit   (rs1_bit),
        .b_bit   (imm_bit),
        .addr    (addr),
        .low     (low)
    );

    lsu_lane #(.XLEN(XLEN)) u_lane (
        .size  (s_q.size),
        .uns   (s_q.uns),
        .off   (addr[1:0]),
        .sdata (s_q.data),
        .rdata (bus_rdat),
        .sel   (bus_sel),
        .wdat  (bus_wdat),
        .ldat  (lane_ldat)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            ST_IDLE: begin
                if (op_start) begin
                    s_d.state = ST_INIT;
                    s_d.cnt   = '0;
                    s_d.store = op_store;
                    s_d.size  = op_size;
                    s_d.uns   = op_unsigned;
                end
            end
            ST_INIT: begin
                s_d.data = {rs2_bit, s_q.data[XLEN-1:1]};
                s_d.cnt  = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_MAX)
                    s_d.state = is_misaligned(s_q.size, low) ? ST_TRAP : ST_BUS;
            end
            ST_BUS: begin
                if (bus_ack) begin
                    s_d.state = ST_FINAL;
                    s_d.cnt   = '0;
                    s_d.ldat  = lane_ldat;
                end
            end
            ST_FINAL: begin
                s_d.ldat = {1'b0, s_q.ldat[XLEN-1:1]};
                s_d.cnt  = s_q.cnt + 1'b1;
                if (s_q.cnt == CNT_MAX) s_d.state = ST_IDLE;
            end
            ST_TRAP: s_d.state = ST_IDLE;
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign init       = (s_q.state == ST_INIT);
    assign bus_cyc    = (s_q.state == ST_BUS);
    assign bus_we     = bus_cyc & s_q.store;
    assign bus_adr    = {addr[XLEN-1:2], 2'b00};
    assign rd_bit     = s_q.ldat[0];
    assign rd_we      = (s_q.state == ST_FINAL) && !s_q.store;
    assign op_done    = (s_q.state == ST_FINAL) && (s_q.cnt == CNT_MAX);
    assign trap       = (s_q.state == ST_TRAP);
    assign trap_cause = trap ? (s_q.store ? CAUSE_STORE_MISALIGN : CAUSE_LOAD_MISALIGN) : 4'd0;
    assign trap_val   = addr;

    // R3: strobe appears only straight after the first pass
    a_r3_cyc_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cyc) |-> $past(init));
    // R3: strobe held while waiting for acknowledge
    a_r3_cyc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && !bus_ack |=> bus_cyc);
    // R3: strobe dropped after acknowledge
    a_r3_cyc_drop: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && bus_ack |=> !bus_cyc);
    // R4: lane mask has one, two or four lanes during an access
    a_r4_sel_shape: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> ($countones(bus_sel) == 1 || $countones(bus_sel) == 2 ||
                     $countones(bus_sel) == NB));
    // R5: load write-back starts only after a completed bus cycle
    a_r5_rd_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_we) |-> $past(bus_cyc && bus_ack));
    // R6: trap is a single-cycle pulse following the first pass, no bus after it
    a_r6_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap && !bus_cyc);
    a_r6_trap_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(init));
    // R7: byte accesses never trap
    a_r7_byte_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> s_q.size != SZ_BYTE);

endmodule

// File: tb/sim_lsu_serial_seq.sv
`timescale 1ns/1ps
module sim_lsu_serial_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0, op_store = 1'b0, op_unsigned = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic        rs1_bit = 1'b0, imm_bit = 1'b0, rs2_bit = 1'b0;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdat = '0;
    logic        bus_cyc, bus_we, init, rd_bit, rd_we, op_done, trap;
    logic [31:0] bus_adr, bus_wdat, trap_val;
    logic [3:0]  bus_sel, trap_cause;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          is_trap;
        bit          is_store;
        logic [31:0] adr;
        logic [3:0]  sel;
        logic [31:0] wdat;
        logic [31:0] rd;
        logic [3:0]  cause;
        logic [31:0] tval;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    lsu_serial_seq u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_store(op_store),
        .op_size(op_size), .op_unsigned(op_unsigned), .rs1_bit(rs1_bit),
        .imm_bit(imm_bit), .rs2_bit(rs2_bit), .bus_ack(bus_ack), .bus_rdat(bus_rdat),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_adr(bus_adr), .bus_sel(bus_sel),
        .bus_wdat(bus_wdat), .init(init), .rd_bit(rd_bit), .rd_we(rd_we),
        .op_done(op_done), .trap(trap), .trap_cause(trap_cause), .trap_val(trap_val)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver: compute expectation from the requirements, queue it, then drive
    task automatic run_op(input bit st, input logic [1:0] sz, input bit un,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] d,
                          input logic [31:0] rdat, input int wait_n, input bit poke);
        exp_t e;
        logic [31:0] ad, sh;
        bit mis;
        ad = a + b;
        mis = (sz == 2'd0) ? 1'b0 : (sz == 2'd1) ? ad[0] : (ad[1] | ad[0]);
        e.is_trap  = mis;
        e.is_store = st;
        e.adr      = {ad[31:2], 2'b00};
        e.tval     = ad;
        e.cause    = st ? 4'd6 : 4'd4;
        if (sz == 2'd0) begin
            e.sel  = 4'b0001 << ad[1:0];
            e.wdat = {4{d[7:0]}};
        end else if (sz == 2'd1) begin
            e.sel  = ad[1] ? 4'b1100 : 4'b0011;
            e.wdat = {2{d[15:0]}};
        end else begin
            e.sel  = 4'b1111;
            e.wdat = d;
        end
        sh = rdat >> (8 * ad[1:0]);
        if (sz == 2'd0)      e.rd = {{24{~un & sh[7]}}, sh[7:0]};
        else if (sz == 2'd1) e.rd = {{16{~un & sh[15]}}, sh[15:0]};
        else                 e.rd = sh;
        exp_q.push_back(e);

        @(negedge clk);
        op_start = 1'b1; op_store = st; op_size = sz; op_unsigned = un;
        @(negedge clk);
        op_start = 1'b0;
        for (int k = 0; k < 32; k++) begin
            rs1_bit = a[k]; imm_bit = b[k]; rs2_bit = d[k];
            @(negedge clk);
        end
        if (mis) begin
            chk(bus_cyc == 1'b0, "R6 no bus cycle on misalign", {31'd0, bus_cyc}, 32'd0);
            @(negedge clk);
            chk(trap == 1'b0, "R6 trap lasts one cycle", {31'd0, trap}, 32'd0);
        end else begin
            chk(bus_cyc == 1'b1, "R3 cyc rises after first pass", {31'd0, bus_cyc}, 32'd1);
            for (int w = 0; w < wait_n; w++) begin
                if (poke && w == 0) begin
                    op_start = 1'b1; op_store = ~st; op_size = ~sz; op_unsigned = ~un;
                end
                @(negedge clk);
                op_start = 1'b0;
                chk(bus_cyc == 1'b1, "R3 cyc held until ack", {31'd0, bus_cyc}, 32'd1);
            end
            op_store = st; op_size = sz; op_unsigned = un;
            bus_ack = 1'b1; bus_rdat = rdat;
            @(negedge clk);
            bus_ack = 1'b0; bus_rdat = 32'h0;
            chk(bus_cyc == 1'b0, "R3 cyc drops after ack", {31'd0, bus_cyc}, 32'd0);
            repeat (32) @(negedge clk);
        end
    endtask

    // Monitor: pop expectations as results appear
    initial begin
        exp_t cur;
        bit cyc_prev = 1'b0;
        int rd_cnt = 0;
        logic [31:0] rd_acc = '0;
        cur = '{default: '0};
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (bus_cyc && !cyc_prev) begin
                    if (exp_q.size() == 0) chk(1'b0, "R3 unexpected bus cycle", 32'd1, 32'd0);
                    else begin
                        cur = exp_q.pop_front();
                        chk(!cur.is_trap, "R7 aligned access expected trap", 32'd0, 32'd1);
                        chk(bus_adr == cur.adr, "R2 bus address", bus_adr, cur.adr);
                        chk(bus_we == cur.is_store, "R4 write enable", {31'd0, bus_we}, {31'd0, cur.is_store});
                        chk(bus_sel == cur.sel, "R4 lane mask", {28'd0, bus_sel}, {28'd0, cur.sel});
                        if (cur.is_store) chk(bus_wdat == cur.wdat, "R4 write data", bus_wdat, cur.wdat);
                    end
                    rd_cnt = 0; rd_acc = '0;
                end
                if (rd_we) begin
                    if (rd_cnt < 32) rd_acc[rd_cnt] = rd_bit;
                    rd_cnt++;
                end
                if (op_done) begin
                    if (cur.is_store)
                        chk(rd_cnt == 0, "R8 store leaves rd untouched", rd_cnt, 32'd0);
                    else begin
                        chk(rd_cnt == 32, "R5 load rd strobe count", rd_cnt, 32'd32);
                        chk(rd_acc == cur.rd, "R5 load result", rd_acc, cur.rd);
                    end
                end
                if (trap) begin
                    if (exp_q.size() == 0) chk(1'b0, "R6 unexpected trap", 32'd1, 32'd0);
                    else begin
                        cur = exp_q.pop_front();
                        chk(cur.is_trap, "R7 trap on aligned access", 32'd1, 32'd0);
                        chk(trap_cause == cur.cause, "R6 trap cause", {28'd0, trap_cause}, {28'd0, cur.cause});
                        chk(trap_val == cur.tval, "R6 trap value", trap_val, cur.tval);
                    end
                end
                cyc_prev = bus_cyc;
            end
        end
    end

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(bus_cyc == 1'b0 && bus_we == 1'b0, "R1 bus idle after reset", {30'd0, bus_cyc, bus_we}, 32'd0);
        chk(trap == 1'b0 && rd_we == 1'b0 && op_done == 1'b0, "R1 status low after reset",
            {29'd0, trap, rd_we, op_done}, 32'd0);

        // loads (R2, R3, R5)
        run_op(1'b0, 2'd2, 1'b0, 32'h0000_1000, 32'h0000_0024, 32'h0, 32'hDEAD_BEEF, 2, 1'b0);
        run_op(1'b0, 2'd0, 1'b0, 32'h0000_2001, 32'h0000_0002, 32'h0, 32'h80FF_1234, 0, 1'b0);
        run_op(1'b0, 2'd0, 1'b1, 32'h0000_2001, 32'h0000_0002, 32'h0, 32'h80FF_1234, 1, 1'b0);
        // R9: start poked while waiting on the bus
        run_op(1'b0, 2'd1, 1'b0, 32'h0000_3000, 32'h0000_0002, 32'h0, 32'h9ABC_5678, 3, 1'b1);
        run_op(1'b0, 2'd1, 1'b1, 32'h0000_3000, 32'h0000_0000, 32'h0, 32'h9ABC_5678, 1, 1'b0);
        // stores (R4, R8), first with wrap-around address
        run_op(1'b1, 2'd2, 1'b0, 32'hFFFF_FFF0, 32'h0000_0014, 32'h1122_3344, 32'h0, 1, 1'b0);
        run_op(1'b1, 2'd0, 1'b0, 32'h0000_4000, 32'h0000_0001, 32'h5555_55AB, 32'h0, 2, 1'b1);
        run_op(1'b1, 2'd1, 1'b0, 32'h0000_4000, 32'h0000_0002, 32'h1234_CAFE, 32'h0, 0, 1'b0);
        // misaligned (R6, R7)
        run_op(1'b0, 2'd2, 1'b0, 32'h0000_1000, 32'h0000_0002, 32'h0, 32'h0, 0, 1'b0);
        run_op(1'b1, 2'd1, 1'b0, 32'h0000_0100, 32'h0000_0001, 32'hAAAA_AAAA, 32'h0, 0, 1'b0);
        run_op(1'b1, 2'd3, 1'b0, 32'h0000_0005, 32'h0000_0002, 32'h0, 32'h0, 0, 1'b0);
        run_op(1'b0, 2'd1, 1'b1, 32'h0000_0003, 32'h0000_0000, 32'h0, 32'h0, 0, 1'b0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all queued results observed", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule